// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the command bus over from the main command path while refresh work is in progress. It has two jobs. The first is to issue an auto refresh command and hold clock enable high for the full refresh-cycle time. The second is to put the memory into self refresh and later bring it back out through the fixed wake-up sequence.

The exit proceeds in order:

1. Wait until the clock is reported stable.
2. Raise clock enable.
3. Drive no-ops for the exit-to-non-read interval.
4. Issue a mode-register load that resets the DLL.
5. Drive 200 more no-ops.
6. Return the bus to the main path.

While the block owns the bus it holds `busy` high, so that the main path cannot issue a read, or any other command, too early. A one-cycle `done` pulse marks the return to idle. All waits share one down-counter.

Top module: `sref_seq`

## Requirements
- R1: After reset `cke` is 1, `cmd_n` (`{cs_n,ras_n,cas_n,we_n}`) is the no-op code 4'b0111, `ba` and `addr` are 0, and `busy` and `done` are 0. While idle the block drives no-op with `cke` high.
- R2: An `ar_req` sampled while idle drives the refresh code 4'b0001 with `cke` high on the next cycle. `busy` then stays high for exactly T_RFC cycles, counting the command cycle. `cke` stays high throughout, and every cycle after the command is a no-op.
- R3: An `sr_enter` sampled while idle drives the refresh code 4'b0001 with `cke` low on the next cycle. `cke` then stays low, and `cmd_n` stays no-op, until the exit sequence raises it.
- R4: When `sr_enter` and `ar_req` are sampled together while idle, self refresh is entered.
- R5: After `sr_exit` is sampled in self refresh, `cke` stays low until `clk_stable` is sampled high. `cke` rises on the following cycle. A high `clk_stable` before `sr_exit` has no effect.
- R6: Counting the cycle in which `cke` rises, exactly T_XSNR no-op cycles follow with `cke` high. Then a mode-register load is driven: code 4'b0000, `ba` = 0, and `addr` = MODE_BASE with bit DLL_BIT set (13'h0132 by default).
- R7: After the mode-register load, exactly DLL_NOP (200) no-op cycles follow with `busy` high. `busy` falls on the next cycle, so no read can be issued within 200 cycles of the exit.
- R8: `done` is high for exactly one cycle: the first cycle in which `busy` is low after either sequence.
- R9: An `sr_exit` outside self refresh is ignored. An `sr_enter` or `ar_req` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_req | input | 1 | Request one auto refresh |
| sr_enter | input | 1 | Request self-refresh entry |
| sr_exit | input | 1 | Request self-refresh exit |
| clk_stable | input | 1 | Memory clock reported stable |
| cke | output | 1 | Clock enable to the memory |
| cmd_n | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| ba | output | BA_W | Bank address (0 for mode-register load) |
| addr | output | ADDR_W | Address / op-code |
| busy | output | 1 | Sequencer owns the command bus |
| done | output | 1 | One-cycle pulse on return to idle |

## Verification
All outputs are registered, so a request or `clk_stable` sampled at one edge shows its effect one cycle later. The bench drives inputs and samples outputs on the falling edge, which puts each first result at the next sample. The multi-cycle results cannot be checked at a single sample. For these the bench counts samples from the first visible effect: T_RFC busy cycles for an auto refresh, T_XSNR no-ops from the `cke` rise to the mode-register load, and 200 no-ops from that load to the fall of `busy`. Checking `done` in the same sample as that fall, and again in the next, pins the pulse to one cycle.

// File: rtl/sref_seq.sv
`timescale 1ns/1ps
module sref_seq #(
  parameter int T_RFC    = 10,
  parameter int T_XSNR   = 20,
  parameter int DLL_NOP  = 200,
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int DLL_BIT  = 8,
  parameter logic [ADDR_W-1:0] MODE_BASE = 'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_req,
  input  logic              sr_enter,
  input  logic              sr_exit,
  input  logic              clk_stable,
  output logic              cke,
  output logic [3:0]        cmd_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done
);
  localparam int M1    = (T_RFC > T_XSNR) ? T_RFC : T_XSNR;
  localparam int MAXW  = (M1 > DLL_NOP) ? M1 : DLL_NOP;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;
  localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_BIT;

  typedef enum logic [2:0] {S_IDLE, S_AR, S_SR, S_SRX, S_XSNR, S_DLL} st_t;
  st_t state;
  logic [CNT_W-1:0] cnt;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      cke   <= 1'b1;
      cmd_n <= C_NOP;
      ba    <= '0;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      cmd_n <= C_NOP;
      ba    <= '0;
      addr  <= '0;
      done  <= 1'b0;
      case (state)
        S_IDLE:
          if (sr_enter) begin
            state <= S_SR;
            cmd_n <= C_REF;
            cke   <= 1'b0;
          end else if (ar_req) begin
            state <= S_AR;
            cmd_n <= C_REF;
            cnt   <= CNT_W'(T_RFC - 1);
          end
        S_AR:
          if (cnt == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        S_SR:
          if (sr_exit) state <= S_SRX;
        S_SRX:
          if (clk_stable) begin
            cke   <= 1'b1;
            state <= S_XSNR;
            cnt   <= CNT_W'(T_XSNR - 1);
          end
        S_XSNR:
          if (cnt == '0) begin
            cmd_n <= C_LMR;
            addr  <= MODE_BASE | DLL_MASK;
            state <= S_DLL;
            cnt   <= CNT_W'(DLL_NOP);
          end else cnt <= cnt - 1'b1;
        S_DLL:
          if (cnt == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n) gap <= CNT_W'(DLL_NOP);
    else if (cmd_n == C_LMR) gap <= '0;
    else if (gap < CNT_W'(DLL_NOP)) gap <= gap + 1'b1;
  end

  AST_AR_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == C_REF && cke) |=> (cke && busy)); // R2
  AST_SR_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == C_REF && !cke) |=> !cke); // R3
  AST_CKE_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable)); // R5
  AST_LMR_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == C_LMR) |-> (cke && busy && ba == '0)); // R6
  AST_DLL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (gap >= CNT_W'(DLL_NOP))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (cmd_n == C_NOP && cke)); // R1
endmodule

// File: tb/sref_seq_test.sv
`timescale 1ns/1ps
module sref_seq_test;
  localparam int T_RFC = 10, T_XSNR = 20, DLL_NOP = 200;
  localparam logic [3:0] NOP = 4'b0111, REF = 4'b0001, LMR = 4'b0000;

  logic clk = 0, rst_n = 0, ar_req = 0, sr_enter = 0, sr_exit = 0, clk_stable = 0;
  logic cke, busy, done;
  logic [3:0] cmd_n;
  logic [1:0] ba;
  logic [12:0] addr;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  sref_seq #(.T_RFC(T_RFC), .T_XSNR(T_XSNR), .DLL_NOP(DLL_NOP)) uut (
    .clk(clk), .rst_n(rst_n), .ar_req(ar_req), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .clk_stable(clk_stable), .cke(cke), .cmd_n(cmd_n),
    .ba(ba), .addr(addr), .busy(busy), .done(done));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cke == 1, "R1 cke", cke, 1);
    chk(cmd_n == NOP, "R1 cmd", cmd_n, NOP);
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(ba == 0 && addr == 0, "R1 ba/addr", addr, 0);
  endtask

  task automatic t_autorefresh();
    int n = 0;
    bit bad_cke = 0, bad_cmd = 0;
    ar_req = 1;
    @(negedge clk); ar_req = 0;
    chk(cmd_n == REF && cke && busy, "R2 refresh command", {cmd_n, cke, busy}, {REF, 2'b11});
    while (busy && n < 1000) begin
      n++;
      if (!cke) bad_cke = 1;
      if (n > 1 && cmd_n != NOP) bad_cmd = 1;
      if (n == 3) sr_enter = 1;
      if (n == 4) sr_enter = 0;
      @(negedge clk);
    end
    chk(n == T_RFC, "R2 busy length", n, T_RFC);
    chk(!bad_cke, "R2 cke held", bad_cke, 0);
    chk(!bad_cmd, "R2 nop after refresh", bad_cmd, 0);
    chk(done == 1, "R8 done at idle", done, 1);
    chk(cke == 1, "R9 sr_enter while busy ignored", cke, 1);
    @(negedge clk);
    chk(done == 0, "R8 done single cycle", done, 0);
    chk(busy == 0 && cke == 1, "R9 still idle", {busy, cke}, 2'b01);
  endtask

  task automatic t_exit_idle();
    sr_exit = 1;
    @(negedge clk); sr_exit = 0;
    chk(busy == 0 && cke == 1 && cmd_n == NOP, "R9 sr_exit in idle ignored", {busy, cke, cmd_n}, {2'b01, NOP});
  endtask

  task automatic t_selfrefresh(input bit both);
    int n;
    bit bad = 0;
    sr_enter = 1; ar_req = both;
    @(negedge clk); sr_enter = 0; ar_req = 0;
    chk(cmd_n == REF && !cke && busy, both ? "R4 enter wins" : "R3 enter command",
        {cmd_n, cke, busy}, {REF, 2'b01});
    clk_stable = 1;
    for (int i = 0; i < 6; i++) begin
      if (i == 2) begin ar_req = 1; sr_enter = 1; end
      if (i == 3) begin ar_req = 0; sr_enter = 0; end
      @(negedge clk);
      if (cke || cmd_n != NOP) bad = 1;
    end
    chk(!bad, "R3 R5 R9 cke low, nop in self refresh", bad, 0);
    clk_stable = 0; sr_exit = 1;
    @(negedge clk); sr_exit = 0;
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (cke) bad = 1;
    end
    chk(!bad, "R5 cke waits for clk_stable", bad, 0);
    clk_stable = 1;
    @(negedge clk);
    chk(cke == 1 && cmd_n == NOP, "R5 cke rises", {cke, cmd_n}, {1'b1, NOP});
    n = 0; bad = 0;
    while (cmd_n == NOP && n < 1000) begin
      n++;
      if (!cke || !busy) bad = 1;
      @(negedge clk);
    end
    chk(n == T_XSNR, "R6 nop count before load", n, T_XSNR);
    chk(!bad, "R6 cke high during wait", bad, 0);
    chk(cmd_n == LMR && ba == 0 && addr == 13'h0132, "R6 DLL reset load",
        {cmd_n, ba, addr}, {LMR, 2'b00, 13'h0132});
    @(negedge clk);
    n = 0; bad = 0;
    while (busy && n < 1000) begin
      n++;
      if (cmd_n != NOP || !cke) bad = 1;
      @(negedge clk);
    end
    chk(n == DLL_NOP, "R7 nop cycles after load", n, DLL_NOP);
    chk(!bad, "R7 only nop after load", bad, 0);
    chk(done == 1, "R8 done after exit", done, 1);
    @(negedge clk);
    chk(done == 0, "R8 done single cycle", done, 0);
    clk_stable = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_autorefresh();
    t_exit_idle();
    t_selfrefresh(0);
    t_selfrefresh(1);
    t_autorefresh();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule